// File: doc/BRIEF.md
# Adaptive Pulse Programming Controller

This block runs the write sequence of a device programmer for a memory whose cells can only be cleared from 1 to 0. On a start request it walks every address. It reads the wanted byte from a source port and drives it onto the memory's data bus. It gives the byte short chip-enable program pulses, each one millisecond long. After each pulse it turns the bus around and reads the byte back. When the byte reads back correctly, it gives one longer pulse whose length grows with the number of short pulses the byte needed. A byte that still reads wrong after the attempt limit ends the run with a failure.

Bytes whose wanted value is all ones are already in the erased state, so they get no pulses. When the last address has been handled, the controller drops the supply-select flags back to normal operating conditions. It then reads every address, including the skipped ones, and compares each against the source. On completion it holds `done` together with `pass` or `fail`. On failure it also holds the failing address and a phase bit that tells programming apart from the final check.

All timing is counted in clock cycles. `CYC_PER_MS` sets the length of a short pulse. `SETUP_CYC` sets the minimum setup, hold and bus-float gaps. `READ_CYC` sets how long each read-back is held.

Top module: `pulse_prog_ctrl`

## Requirements
- R1: After reset `done`, `pass` and `fail` are 0, `memCeN` and `memOeN` are 1, `busOe` is 0, and both supply flags are 0.
- R2: Each short pulse holds `memCeN` low for exactly `CYC_PER_MS` cycles, with `busOe` high and both supply flags high. Each read-back holds `memCeN` high and `memOeN` low, with the bus undriven.
- R3: A byte gets one short pulse followed by a read-back, again and again, until the read-back equals the wanted byte. A byte that needs 25 pulses is still programmed successfully.
- R4: A read-back mismatch after the 25th short pulse on a byte ends the run at once. The run ends with `done`=1, `fail`=1, `failPhase`=0 and `failAddr` set to that address.
- R5: After a matching read-back, the byte gets one long pulse of exactly 3 × n × `CYC_PER_MS` cycles. Here n is the number of short pulses that byte received. Then the controller moves to the next address.
- R6: A byte whose wanted value is 8'hFF receives no pulse of any kind.
- R7: Address and data are driven and stable for at least `SETUP_CYC` cycles before `memCeN` falls. The bus stays driven for at least `SETUP_CYC` cycles after `memCeN` rises. The bus is undriven for at least `SETUP_CYC` cycles before `memOeN` falls in a read-back.
- R8: After the last address, both supply flags drop to 0 and every address from 0 to the last is read with `memCeN`=0 and `memOeN`=0. The first mismatch ends the run with `fail`=1, `failPhase`=1 and `failAddr` set to that address.
- R9: At the end of a run, `done` and exactly one of `pass`/`fail` stay asserted until the next `start`, and the data bus is not driven.
- R10: `busOe` and a low `memOeN` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Run finished with every byte correct |
| fail | output | 1 | Run finished with an error |
| failAddr | output | ADDR_W | Address at which the run failed |
| failPhase | output | 1 | 0 = failed while programming, 1 = failed in final check |
| srcAddr | output | ADDR_W | Address of the source-data read port |
| srcData | input | 8 | Wanted byte at `srcAddr`, combinational read |
| memAddr | output | ADDR_W | Memory address pins |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| busOut | output | 8 | Data driven towards the memory |
| busIn | input | 8 | Data read from the memory |
| busOe | output | 1 | Drive enable for `busOut` |
| vccHigh | output | 1 | Requests raised core supply for programming |
| vppHigh | output | 1 | Requests programming supply |

## Verification
The bound checker watches the bus and control pins on every cycle. It checks that the bus is never driven while output enable is low, that read-backs and final-check reads leave the bus undriven, that the setup, hold and float gaps are met, and that a failure always comes with `done` and a released bus. Only the bench scenarios can show the adaptive part of the flow. That covers the number of short pulses each byte receives against a memory model that needs a set count, the length of each long pulse relative to that count, the skipping of all-ones bytes, failure at the 25-pulse limit, and final-check failures that appear only under normal supply conditions.

// File: rtl/pulse_prog_pkg.sv
package pulse_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_SETUP, ST_PULSE, ST_HOLD,
    ST_FLOAT, ST_VERIFY, ST_NEXT, ST_CHECK, ST_DONE
  } progState_t;

  // which interval the shared timer is loaded with
  typedef enum logic [1:0] {
    TM_SETUP, TM_SHORT, TM_OVER, TM_READ
  } timerSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadTimer;
    timerSel_t timerSel;
    logic      clrAddr;
    logic      incAddr;
    logic      clrTries;
    logic      incTries;
    logic      latchData;
    logic      setFail;
    logic      failPhase;
    logic      clrFail;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic timerDone;
    logic addrLast;
    logic srcBlank;
    logic triesMax;
    logic verifyOk;
    logic checkOk;
  } dpStatus_t;

endpackage

// File: rtl/pulse_prog_dp.sv
module pulse_prog_dp
  import pulse_prog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int CYC_PER_MS = 1000,
  parameter int SETUP_CYC  = 2,
  parameter int READ_CYC   = 2,
  parameter int MAX_TRIES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  input  logic [7:0]        srcData,
  input  logic [7:0]        busIn,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        dataReg,
  output logic              failFlag,
  output logic [ADDR_W-1:0] failAddr,
  output logic              failPhase
);

  localparam int TRY_W    = $clog2(MAX_TRIES + 1);
  localparam int OVER_MAX = 3 * MAX_TRIES * CYC_PER_MS;
  localparam int CNT_W    = $clog2(OVER_MAX + 1);

  logic [TRY_W-1:0] tries;
  logic [CNT_W-1:0] timer;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] overLen;

  // long pulse: three short-pulse lengths for every attempt used
  assign overLen = CNT_W'(tries) * CNT_W'(3 * CYC_PER_MS);

  always_comb begin
    case (strobe.timerSel)
      TM_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      TM_SHORT: loadVal = CNT_W'(CYC_PER_MS - 1);
      TM_OVER:  loadVal = overLen - 1'b1;
      default:  loadVal = CNT_W'(READ_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                timer <= '0;
    else if (strobe.loadTimer) timer <= loadVal;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               addr <= '0;
    else if (strobe.clrAddr)  addr <= '0;
    else if (strobe.incAddr)  addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clrTries) tries <= TRY_W'(1);
    else if (strobe.incTries)      tries <= tries + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                dataReg <= '1;
    else if (strobe.latchData) dataReg <= srcData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clrFail) begin
      failFlag  <= 1'b0;
      failAddr  <= '0;
      failPhase <= 1'b0;
    end else if (strobe.setFail) begin
      failFlag  <= 1'b1;
      failAddr  <= addr;
      failPhase <= strobe.failPhase;
    end
  end

  assign status.timerDone = (timer == '0);
  assign status.addrLast  = (addr == '1);
  assign status.srcBlank  = (srcData == 8'hFF);
  assign status.triesMax  = (tries == TRY_W'(MAX_TRIES));
  assign status.verifyOk  = (busIn == dataReg);
  assign status.checkOk   = (busIn == srcData);

endmodule

// File: rtl/pulse_prog_fsm.sv
module pulse_prog_fsm
  import pulse_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       memCeN,
  output logic       memOeN,
  output logic       busOe,
  output logic       progSupply,
  output logic       done
);

  progState_t state, nxt;
  logic overPh, setOver, clrOver;

  always_comb begin
    strobe  = '0;
    nxt     = state;
    setOver = 1'b0;
    clrOver = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: if (start) begin
        nxt             = ST_LOAD;
        strobe.clrAddr  = 1'b1;
        strobe.clrTries = 1'b1;
        strobe.clrFail  = 1'b1;
        clrOver         = 1'b1;
      end
      ST_LOAD: begin
        strobe.latchData = 1'b1;
        if (status.srcBlank) nxt = ST_NEXT;
        else begin
          nxt              = ST_SETUP;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TM_SETUP;
        end
      end
      ST_SETUP: if (status.timerDone) begin
        nxt              = ST_PULSE;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = overPh ? TM_OVER : TM_SHORT;
      end
      ST_PULSE: if (status.timerDone) begin
        nxt              = ST_HOLD;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TM_SETUP;
      end
      ST_HOLD: if (status.timerDone) begin
        if (overPh) nxt = ST_NEXT;
        else begin
          nxt              = ST_FLOAT;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TM_SETUP;
        end
      end
      ST_FLOAT: if (status.timerDone) begin
        nxt              = ST_VERIFY;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TM_READ;
      end
      ST_VERIFY: if (status.timerDone) begin
        if (status.verifyOk) begin
          nxt              = ST_SETUP;
          setOver          = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TM_SETUP;
        end else if (status.triesMax) begin
          nxt              = ST_DONE;
          strobe.setFail   = 1'b1;
          strobe.failPhase = 1'b0;
        end else begin
          nxt              = ST_SETUP;
          strobe.incTries  = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TM_SETUP;
        end
      end
      ST_NEXT: begin
        strobe.clrTries = 1'b1;
        clrOver         = 1'b1;
        if (status.addrLast) begin
          nxt              = ST_CHECK;
          strobe.clrAddr   = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TM_READ;
        end else begin
          nxt            = ST_LOAD;
          strobe.incAddr = 1'b1;
        end
      end
      ST_CHECK: if (status.timerDone) begin
        if (!status.checkOk) begin
          nxt              = ST_DONE;
          strobe.setFail   = 1'b1;
          strobe.failPhase = 1'b1;
        end else if (status.addrLast) begin
          nxt = ST_DONE;
        end else begin
          strobe.incAddr   = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TM_READ;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      overPh <= 1'b0;
    end else begin
      state <= nxt;
      if (clrOver)      overPh <= 1'b0;
      else if (setOver) overPh <= 1'b1;
    end
  end

  assign memCeN     = !(state == ST_PULSE || state == ST_CHECK);
  assign memOeN     = !(state == ST_VERIFY || state == ST_CHECK);
  assign busOe      = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
  assign progSupply = (state == ST_LOAD) || (state == ST_SETUP) || (state == ST_PULSE) ||
                      (state == ST_HOLD) || (state == ST_FLOAT) || (state == ST_VERIFY) ||
                      (state == ST_NEXT);
  assign done       = (state == ST_DONE);

endmodule

// File: rtl/pulse_prog_ctrl.sv
module pulse_prog_ctrl
  import pulse_prog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int CYC_PER_MS = 1000,
  parameter int SETUP_CYC  = 2,
  parameter int READ_CYC   = 2,
  parameter int MAX_TRIES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic              failPhase,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [7:0]        srcData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic [7:0]        busOut,
  input  logic [7:0]        busIn,
  output logic              busOe,
  output logic              vccHigh,
  output logic              vppHigh
);

  ctlStrobe_t        strobe;
  dpStatus_t         status;
  logic [ADDR_W-1:0] addr;
  logic              failFlag;
  logic              progSupply;

  pulse_prog_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .status(status), .strobe(strobe),
    .memCeN(memCeN), .memOeN(memOeN), .busOe(busOe),
    .progSupply(progSupply), .done(done)
  );

  pulse_prog_dp #(
    .ADDR_W(ADDR_W), .CYC_PER_MS(CYC_PER_MS), .SETUP_CYC(SETUP_CYC),
    .READ_CYC(READ_CYC), .MAX_TRIES(MAX_TRIES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .status(status),
    .srcData(srcData), .busIn(busIn), .addr(addr), .dataReg(busOut),
    .failFlag(failFlag), .failAddr(failAddr), .failPhase(failPhase)
  );

  assign srcAddr = addr;
  assign memAddr = addr;
  assign vccHigh = progSupply;
  assign vppHigh = progSupply;
  assign pass    = done && !failFlag;
  assign fail    = done && failFlag;

endmodule

// File: rtl/pulse_prog_chk.sv
module pulse_prog_chk #(
  parameter int ADDR_W    = 15,
  parameter int SETUP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic [7:0]        busOut,
  input logic              busOe,
  input logic              vppHigh
);

  localparam int CW = $clog2(SETUP_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0]     drvCnt, holdCnt, floatCnt;
  logic [7:0]        prevOut;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drvCnt <= '0; holdCnt <= '0; floatCnt <= '0;
      prevOut <= '0; prevAddr <= '0;
    end else begin
      prevOut  <= busOut;
      prevAddr <= memAddr;
      if (!busOe)                                          drvCnt <= '0;
      else if (busOut != prevOut || memAddr != prevAddr)   drvCnt <= CW'(1);
      else if (drvCnt != CMAX)                             drvCnt <= drvCnt + 1'b1;
      if (!memCeN)               holdCnt <= '0;
      else if (holdCnt != CMAX)  holdCnt <= holdCnt + 1'b1;
      if (busOe)                 floatCnt <= '0;
      else if (floatCnt != CMAX) floatCnt <= floatCnt + 1'b1;
    end
  end

  assert_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memCeN) && vppHigh |-> drvCnt >= CW'(SETUP_CYC));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busOe) && vppHigh |-> holdCnt >= CW'(SETUP_CYC));
  assert_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memOeN) && vppHigh |-> floatCnt >= CW'(SETUP_CYC));
  assert_pulse_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !memCeN && vppHigh |-> busOe);
  assert_verify_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN && vppHigh |-> memCeN && !busOe);
  assert_check_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !memCeN && !vppHigh |-> !memOeN && !busOe);
  assert_fail_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done && !busOe && !vppHigh);
  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busOe |-> memOeN);

endmodule

bind pulse_prog_ctrl pulse_prog_chk #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .fail(fail), .memAddr(memAddr),
  .memCeN(memCeN), .memOeN(memOeN), .busOut(busOut), .busOe(busOe), .vppHigh(vppHigh)
);

// File: tb/pulse_prog_ctrl_tb_top.sv
module pulse_prog_ctrl_tb_top;

  localparam int AW    = 4;
  localparam int NADDR = 1 << AW;
  localparam int CYC   = 20;
  localparam int SETUP = 2;

  // per address: {wanted byte, short pulses the model needs}
  localparam logic [13:0] VEC [NADDR] = '{
    {8'hA5, 6'd1}, {8'hFF, 6'd0}, {8'h00, 6'd3}, {8'h3C, 6'd25},
    {8'h7E, 6'd2}, {8'hFF, 6'd0}, {8'h01, 6'd1}, {8'h80, 6'd4},
    {8'h55, 6'd1}, {8'hAA, 6'd2}, {8'h0F, 6'd1}, {8'hF0, 6'd5},
    {8'h12, 6'd1}, {8'h34, 6'd2}, {8'h56, 6'd1}, {8'h78, 6'd3}
  };

  logic clk = 1'b0;
  logic rst_n, start, eraseReq;
  logic done, pass, fail, failPhase, memCeN, memOeN, busOe, vccHigh, vppHigh;
  logic [AW-1:0] failAddr, srcAddr, memAddr;
  logic [7:0] srcData, busOut, busIn;

  logic [7:0] srcMem [NADDR];
  logic [7:0] corrupt [NADDR];
  int needV [NADDR];
  logic [7:0] mem [NADDR];
  int pulseCnt [NADDR], overCnt [NADDR], overLen [NADDR];
  int lowCnt, drvRun, holdRun, minSetup, minHold, contention;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pulse_prog_ctrl #(.ADDR_W(AW), .CYC_PER_MS(CYC), .SETUP_CYC(SETUP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass), .fail(fail),
    .failAddr(failAddr), .failPhase(failPhase), .srcAddr(srcAddr), .srcData(srcData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .busOut(busOut),
    .busIn(busIn), .busOe(busOe), .vccHigh(vccHigh), .vppHigh(vppHigh)
  );

  assign srcData = srcMem[srcAddr];
  assign busIn = !memOeN ? (mem[memAddr] ^ (vppHigh ? 8'h00 : corrupt[memAddr])) : 8'h00;

  // memory model: a byte takes its programmed value after needV short pulses
  always @(negedge clk) begin
    if (eraseReq) begin
      for (int i = 0; i < NADDR; i++) begin
        mem[i] = 8'hFF; pulseCnt[i] = 0; overCnt[i] = 0; overLen[i] = 0;
      end
      lowCnt = 0; drvRun = 0; holdRun = 0;
      minSetup = 999; minHold = 999; contention = 0;
    end else begin
      if (busOe && !memOeN) contention++;
      if (!memCeN && vppHigh) begin
        if (lowCnt == 0 && drvRun < minSetup) minSetup = drvRun;
        lowCnt++;
        holdRun = 0;
      end else begin
        if (lowCnt > 0) begin
          if (lowCnt == CYC) begin
            pulseCnt[memAddr]++;
            if (pulseCnt[memAddr] == needV[memAddr]) mem[memAddr] = mem[memAddr] & busOut;
          end else begin
            overCnt[memAddr]++;
            overLen[memAddr] = lowCnt;
          end
          lowCnt = 0;
        end
        if (busOe && vppHigh) holdRun++;
        else if (holdRun > 0) begin
          if (holdRun < minHold) minHold = holdRun;
          holdRun = 0;
        end
      end
      drvRun = busOe ? drvRun + 1 : 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic eraseMem();
    eraseReq = 1'b1;
    @(negedge clk); @(negedge clk);
    eraseReq = 1'b0;
  endtask

  task automatic loadVectors();
    for (int i = 0; i < NADDR; i++) begin
      srcMem[i]  = VEC[i][13:6];
      needV[i]   = int'(VEC[i][5:0]);
      corrupt[i] = 8'h00;
    end
  endtask

  task automatic runOnce(input string tag);
    int w;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 60000) begin @(negedge clk); w++; end
    check(done == 1'b1, {tag, " watchdog/done"}, int'(done), 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; eraseReq = 1'b0;
    loadVectors();
    eraseMem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 0 && pass == 0 && fail == 0, "R1 status", int'({done, pass, fail}), 0);
    check(memCeN == 1 && memOeN == 1, "R1 enables", int'({memCeN, memOeN}), 3);
    check(busOe == 0 && vppHigh == 0 && vccHigh == 0, "R1 bus/supply",
          int'({busOe, vppHigh, vccHigh}), 0);

    // run 1: vector table, everything programs
    runOnce("R3 run1");
    check(pass == 1 && fail == 0, "R9 run1 pass", int'({pass, fail}), 2);
    for (int i = 0; i < NADDR; i++) begin
      if (VEC[i][13:6] == 8'hFF) begin
        check(pulseCnt[i] == 0 && overCnt[i] == 0, $sformatf("R6 addr %0d pulses", i),
              pulseCnt[i] + overCnt[i], 0);
      end else begin
        check(pulseCnt[i] == needV[i], $sformatf("R2/R3 addr %0d short pulses", i),
              pulseCnt[i], needV[i]);
        check(overCnt[i] == 1 && overLen[i] == 3 * needV[i] * CYC,
              $sformatf("R5 addr %0d long pulse", i), overLen[i], 3 * needV[i] * CYC);
      end
      check(mem[i] == VEC[i][13:6], $sformatf("R3 addr %0d contents", i),
            int'(mem[i]), int'(VEC[i][13:6]));
    end
    check(minSetup >= SETUP, "R7 setup", minSetup, SETUP);
    check(minHold >= SETUP, "R7 hold", minHold, SETUP);
    check(contention == 0, "R10 contention", contention, 0);
    repeat (5) @(negedge clk);
    check(done && pass && !busOe && memCeN, "R9 held", int'({done, pass, busOe, memCeN}), 13);

    // run 2: one byte needs more than the limit
    loadVectors();
    needV[6] = 26;
    eraseMem();
    runOnce("R4 run2");
    check(fail == 1 && pass == 0, "R4 fail flag", int'({pass, fail}), 1);
    check(failPhase == 0, "R4 phase", int'(failPhase), 0);
    check(failAddr == 4'd6, "R4 address", int'(failAddr), 6);
    check(pulseCnt[6] == 25, "R4 pulse count", pulseCnt[6], 25);
    check(busOe == 0 && vppHigh == 0, "R9 bus released", int'({busOe, vppHigh}), 0);

    // run 3: last byte only wrong under normal supply
    loadVectors();
    for (int i = 0; i < NADDR; i++) needV[i] = 1;
    corrupt[15] = 8'h01;
    eraseMem();
    runOnce("R8 run3");
    check(fail == 1 && failPhase == 1, "R8 last phase", int'({fail, failPhase}), 3);
    check(failAddr == 4'd15, "R8 last address", int'(failAddr), 15);

    // run 4: skipped all-ones byte still rechecked
    corrupt[15] = 8'h00;
    corrupt[1]  = 8'h80;
    eraseMem();
    runOnce("R8 run4");
    check(fail == 1 && failPhase == 1, "R6/R8 blank phase", int'({fail, failPhase}), 3);
    check(failAddr == 4'd1, "R6/R8 blank address", int'(failAddr), 1);
    check(pulseCnt[1] == 0, "R6 blank unpulsed", pulseCnt[1], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule